// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a handful of recently used page mappings and turns a 32-bit virtual address into a 32-bit physical address within the same cycle. Pages are 4 KB. The low 12 bits of the address pass through unchanged, and the upper bits are replaced by the cached physical page number. Every valid slot is compared in parallel, so a page can sit in any slot. When no slot matches, a miss flag rises combinationally. The pipeline can then stop the access before any result is committed.

A walker or handler loads new mappings through the refill port. The block exposes a use bit and a modified bit for each slot, which support a write-back paging policy. A slot is chosen for replacement only when a refill arrives. The choice approximates least-recently-used by means of the use bits. A flush input and a clear-use input model operating-system maintenance. Refill, flush and clear-use all take effect at the next rising clock edge.

Top module: `tlb_fa`

## Requirements
- R1: When `lk_valid` is 1 and bits 31:12 of `lk_va` equal the page number of a valid slot, `lk_hit` is 1 in the same cycle. In that cycle `lk_pa` equals that slot's physical page number in bits 31:12 and `lk_va[11:0]` in bits 11:0.
- R2: When `lk_valid` is 1 and no valid slot matches, `lk_miss` is 1 and `lk_hit` is 0 in the same cycle. When `lk_valid` is 0, both flags are 0.
- R3: A hit sets that slot's use bit (`ent_use[i]`, bit i for slot i) at the next edge.
- R4: A hit with `lk_write` set to 1 also sets that slot's modified bit (`ent_mod[i]`). A hit with `lk_write` at 0 leaves the modified bit unchanged.
- R5: A refill whose page number is not present goes to the lowest-indexed invalid slot. After the next edge that slot is valid, holds the refill mapping, and has its use and modified bits at 0.
- R6: When every slot is valid, a new refill replaces the lowest-indexed slot whose use bit is 0.
- R7: When every slot is valid and every use bit is 1, a new refill replaces slot 0 and clears all use bits. The only exception is a bit set by a hit in the same cycle.
- R8: A refill whose page number matches a valid slot overwrites that slot, with use and modified bits at 0, and never creates a second copy.
- R9: `flush` clears every valid, use and modified bit at the next edge. It takes priority over a refill in the same cycle.
- R10: `clr_use` zeroes every use bit at the next edge and takes priority over a hit in the same cycle. A write hit in that cycle still sets the modified bit.
- R11: After the synchronous active-high reset, all valid, use and modified bits are 0 and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Translation found (combinational) |
| lk_miss | output | 1 | Translation absent, access must stop (combinational) |
| lk_pa | output | 32 | Translated physical address |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_ppn | input | 20 | Physical page number to load |
| flush | input | 1 | Invalidate all slots |
| clr_use | input | 1 | Zero all use bits |
| ent_valid | output | 4 | Valid bit per slot |
| ent_use | output | 4 | Use bit per slot |
| ent_mod | output | 4 | Modified bit per slot |

## Verification
The hardest state to reach from the ports is a full buffer in which every use bit is set at the moment a new page arrives. Only in that state does the sweep that clears all use bits and evicts slot 0 occur. A directed sequence fills four slots, touches each one, and then refills. The random phase draws page numbers from a pool of six with frequent lookups, which keeps the buffer full and hot so that sweeps recur. Those sweeps also collide with same-cycle hits, clear-use pulses and duplicate refills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // reason a refill target was chosen
  typedef enum logic [1:0] {
    VIC_FREE  = 2'd0,  // an invalid slot was available
    VIC_COLD  = 2'd1,  // a valid slot with use bit 0
    VIC_SWEEP = 2'd2   // every slot hot: sweep use bits, take slot 0
  } vic_kind_e;
endpackage

// File: rtl/tlb_enc.sv
module tlb_enc #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N     = 4,
  parameter int unsigned VPN_W = 20
) (
  input  logic [N*VPN_W-1:0] tags,
  input  logic [N-1:0]       valid,
  input  logic [VPN_W-1:0]   key,
  output logic [N-1:0]       match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g*VPN_W +: VPN_W] == key);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     use_bits,
  output logic [IDX_W-1:0] idx,
  output vic_kind_e        kind
);
  logic             free_any, cold_any;
  logic [IDX_W-1:0] free_idx, cold_idx;

  tlb_enc #(.N(N), .IDX_W(IDX_W)) u_free (
    .vec(~valid), .any(free_any), .idx(free_idx)
  );
  tlb_enc #(.N(N), .IDX_W(IDX_W)) u_cold (
    .vec(~use_bits), .any(cold_any), .idx(cold_idx)
  );

  always_comb begin
    if (free_any) begin
      idx  = free_idx;
      kind = VIC_FREE;
    end else if (cold_any) begin
      idx  = cold_idx;
      kind = VIC_COLD;
    end else begin
      idx  = '0;
      kind = VIC_SWEEP;
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned OFFS_W = 12,
  parameter int unsigned N      = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_va,
  input  logic                   lk_write,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PA_W-1:0]        lk_pa,
  input  logic                   fill_en,
  input  logic [VA_W-OFFS_W-1:0] fill_vpn,
  input  logic [PA_W-OFFS_W-1:0] fill_ppn,
  input  logic                   flush,
  input  logic                   clr_use,
  output logic [N-1:0]           ent_valid,
  output logic [N-1:0]           ent_use,
  output logic [N-1:0]           ent_mod
);
  localparam int unsigned VPN_W = VA_W - OFFS_W;
  localparam int unsigned PPN_W = PA_W - OFFS_W;
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  // mapping storage (no reset; qualified by valid bits)
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     valid_q, use_q, mod_q;
  logic [N-1:0]     valid_d, use_d, mod_d;
  logic [N*VPN_W-1:0] tag_flat;

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign tag_flat[g*VPN_W +: VPN_W] = vpn_q[g];
  end

  // lookup path
  logic [N-1:0]     lk_match;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;

  tlb_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
    .tags(tag_flat), .valid(valid_q), .key(lk_va[VA_W-1:OFFS_W]), .match(lk_match)
  );
  tlb_enc #(.N(N), .IDX_W(IDX_W)) u_lk_enc (
    .vec(lk_match), .any(lk_any), .idx(lk_idx)
  );

  assign lk_hit  = lk_valid && lk_any;
  assign lk_miss = lk_valid && !lk_any;
  assign lk_pa   = lk_hit ? {ppn_q[lk_idx], lk_va[OFFS_W-1:0]} : '0;

  // refill path: duplicate detection, then victim choice
  logic [N-1:0]     dup_match;
  logic             dup_any;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] vic_idx;
  vic_kind_e        vic_kind;
  logic [IDX_W-1:0] fill_idx;
  logic             sweep;

  tlb_match #(.N(N), .VPN_W(VPN_W)) u_dup_match (
    .tags(tag_flat), .valid(valid_q), .key(fill_vpn), .match(dup_match)
  );
  tlb_enc #(.N(N), .IDX_W(IDX_W)) u_dup_enc (
    .vec(dup_match), .any(dup_any), .idx(dup_idx)
  );
  tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .valid(valid_q), .use_bits(use_q), .idx(vic_idx), .kind(vic_kind)
  );

  assign fill_idx = dup_any ? dup_idx : vic_idx;
  assign sweep    = fill_en && !dup_any && (vic_kind == VIC_SWEEP);

  // status next state: clears, then hit updates, then refill, then flush
  always_comb begin
    valid_d = valid_q;
    use_d   = use_q;
    mod_d   = mod_q;
    if (clr_use || sweep) use_d = '0;
    if (lk_hit) begin
      if (!clr_use) use_d[lk_idx] = 1'b1;
      if (lk_write) mod_d[lk_idx] = 1'b1;
    end
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      use_d[fill_idx]   = 1'b0;
      mod_d[fill_idx]   = 1'b0;
    end
    if (flush) begin
      valid_d = '0;
      use_d   = '0;
      mod_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      use_q   <= '0;
      mod_q   <= '0;
    end else begin
      valid_q <= valid_d;
      use_q   <= use_d;
      mod_q   <= mod_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush && !rst) begin
      vpn_q[fill_idx] <= fill_vpn;
      ppn_q[fill_idx] <= fill_ppn;
    end
  end

  assign ent_valid = valid_q;
  assign ent_use   = use_q;
  assign ent_mod   = mod_q;

  // ---------------- assertions ----------------
  assert_single_match_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  assert_hit_valid_R1: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> ent_valid[lk_idx]);

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_valid == '0 && ent_use == '0 && ent_mod == '0));

  assert_clr_use_R10: assert property (@(posedge clk) disable iff (rst)
    clr_use |=> (ent_use == '0));

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_use_set_R3: assert property (@(posedge clk) disable iff (rst)
      (lk_hit && lk_idx == IDX_W'(g) && !clr_use && !flush &&
       !(fill_en && fill_idx == IDX_W'(g))) |=> ent_use[g]);

    assert_mod_set_R4: assert property (@(posedge clk) disable iff (rst)
      (lk_hit && lk_write && lk_idx == IDX_W'(g) && !flush &&
       !(fill_en && fill_idx == IDX_W'(g))) |=> ent_mod[g]);

    assert_fill_load_R5: assert property (@(posedge clk) disable iff (rst)
      (fill_en && !flush && fill_idx == IDX_W'(g)) |=>
        (ent_valid[g] && !ent_use[g] && !ent_mod[g]));
  end
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        flush = 1'b0, clr_use = 1'b0;
  logic [N-1:0] ent_valid, ent_use, ent_mod;

  int total = 0;
  int bad   = 0;

  // reference model
  bit [19:0] m_vpn [N];
  bit [19:0] m_ppn [N];
  bit [N-1:0] m_v = '0, m_u = '0, m_d = '0;

  always #2 clk = ~clk;  // 250 MHz

  tlb_fa u_tlb_fa (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .flush(flush), .clr_use(clr_use),
    .ent_valid(ent_valid), .ent_use(ent_use), .ent_mod(ent_mod)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int find(input bit [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  // one cycle: drive at negedge, check lookup, model edge, check status
  task automatic step(input string tag, input bit lv, input bit [31:0] va, input bit wr,
                      input bit fe, input bit [19:0] fv, input bit [19:0] fp,
                      input bit fl, input bit cr);
    int h, t;
    bit sw;
    @(negedge clk);
    lk_valid = lv; lk_va = va; lk_write = wr;
    fill_en = fe; fill_vpn = fv; fill_ppn = fp; flush = fl; clr_use = cr;
    #1;
    h = lv ? find(va[31:12]) : -1;
    chk(lv ? (h >= 0 ? "R1" : "R2") : "R2", "hit", 32'(lk_hit), 32'(h >= 0));
    chk("R2", "miss", 32'(lk_miss), 32'(lv && h < 0));
    if (h >= 0) chk("R1", "pa", lk_pa, {m_ppn[h], va[11:0]});
    // model target
    sw = 1'b0;
    t = find(fv);
    if (t < 0) begin
      for (int i = 0; i < N; i++) if (!m_v[i] && t < 0) t = i;
      if (t < 0) for (int i = 0; i < N; i++) if (!m_u[i] && t < 0) t = i;
      if (t < 0) begin t = 0; sw = 1'b1; end
    end
    @(posedge clk);
    if (cr || (fe && sw)) m_u = '0;
    if (h >= 0) begin
      if (!cr) m_u[h] = 1'b1;
      if (wr) m_d[h] = 1'b1;
    end
    if (fe) begin
      m_v[t] = 1'b1; m_u[t] = 1'b0; m_d[t] = 1'b0;
      if (!fl) begin m_vpn[t] = fv; m_ppn[t] = fp; end
    end
    if (fl) begin m_v = '0; m_u = '0; m_d = '0; end
    #1;
    chk(tag, "valid", 32'(ent_valid), 32'(m_v));
    chk(tag, "use", 32'(ent_use), 32'(m_u));
    chk(tag, "mod", 32'(ent_mod), 32'(m_d));
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [19:0] pool [6];
    void'($urandom(32'd7741));
    for (int i = 0; i < 6; i++) pool[i] = 20'h10000 + 20'(i * 37);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R11", "valid", 32'(ent_valid), 0);
    chk("R11", "use", 32'(ent_use), 0);
    chk("R11", "mod", 32'(ent_mod), 0);
    step("R11", 1, {pool[0], 12'h123}, 0, 0, 0, 0, 0, 0);
    // fill four slots in order
    for (int i = 0; i < 4; i++)
      step("R5", 0, 0, 0, 1, pool[i], 20'hA0000 + 20'(i), 0, 0);
    step("R3", 1, {pool[0], 12'hFFF}, 0, 0, 0, 0, 0, 0);
    step("R4", 1, {pool[2], 12'h004}, 1, 0, 0, 0, 0, 0);
    step("R4", 1, {pool[2], 12'h008}, 0, 0, 0, 0, 0, 0);
    step("R2", 1, {pool[4], 12'h000}, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, pool[4], 20'hB0004, 0, 0);   // slot 1 is cold
    step("R8", 0, 0, 0, 1, pool[0], 20'hC0000, 0, 0);   // overwrite in place
    step("R1", 1, {pool[0], 12'h5A5}, 0, 0, 0, 0, 0, 0);
    step("R10", 1, {pool[3], 12'h010}, 1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++)
      step("R3", 1, {(i == 1) ? pool[4] : pool[i], 12'h0}, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, pool[5], 20'hD0005, 0, 0);   // sweep, slot 0
    step("R1", 1, {pool[5], 12'h777}, 0, 0, 0, 0, 0, 0);
    step("R9", 1, {pool[2], 12'h0}, 1, 1, pool[1], 20'hE0001, 1, 0);
    step("R2", 1, {pool[2], 12'h0}, 0, 0, 0, 0, 0, 0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit lv, wr, fe, fl, cr;
      string tg;
      lv = ($urandom % 4) != 0;
      wr = $urandom % 2;
      fe = ($urandom % 5) == 0;
      fl = ($urandom % 97) == 0;
      cr = ($urandom % 23) == 0;
      tg = fl ? "R9" : fe ? "R6" : cr ? "R10" : (lv && wr) ? "R4" : "R3";
      step(tg, lv, {pool[$urandom % 6], 12'($urandom)}, wr,
           fe, pool[$urandom % 6], 20'($urandom), fl, cr);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule